// File: doc/BRIEF.md
# Element width register file

A store of 128 registers, each 64 bits wide, treated as one flat run of 1024 bytes. Every access names a base register, an element index and an element width of 8, 16, 32 or 64 bits. The block turns these three into a byte address and reads or writes one element there. A 64-bit register therefore acts as eight bytes, four halfwords, two words or one doubleword, depending on the width given with the access.

There are two combinational read ports and one clocked write port. A read returns the selected element, zero-extended to 64 bits. A write changes only the bytes of its element. Every other byte of the affected register keeps its value. Because an index may run past the end of its base register, a single base register plus a growing index walks a vector through consecutive registers.

Top module: `elem_regfile`

## Requirements
- R1: While rstN is low every register is cleared, so after reset every read returns zero.
- R2: Width code 2'b00 selects 64-bit elements, 2'b01 8-bit, 2'b10 16-bit and 2'b11 32-bit. Read data holds the element in its low bits and zeros above it.
- R3: The byte address of an element is (base*8 + index*bytes) modulo 1024. Byte address a is register a/8, bits 8*(a%8)+7 down to 8*(a%8). An element's lowest byte holds its least significant bits. Addresses past register 127 wrap to register 0.
- R4: An index beyond the element count of the base register selects an element in a following register. For example, base 3, index 9, 8-bit width selects register 4, bits 15:8.
- R5: A write changes only the bytes of the selected element. The other bytes of that register, and all other registers, are unchanged.
- R6: Bits of wrData above the element width are ignored.
- R7: A write takes effect at the rising clock edge. A read of the same element in the same cycle returns the old value, and a read in the next cycle returns the new value.
- R8: The two read ports are independent. Each returns its own element, and both return the same data when given the same address.
- R9: When wrEn is low, no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| rdBaseA | input | 7 | Read port A base register |
| rdIdxA | input | 7 | Read port A element index |
| rdWidA | input | 2 | Read port A element width code |
| rdDataA | output | 64 | Read port A data, zero-extended |
| rdBaseB | input | 7 | Read port B base register |
| rdIdxB | input | 7 | Read port B element index |
| rdWidB | input | 2 | Read port B element width code |
| rdDataB | output | 64 | Read port B data, zero-extended |
| wrEn | input | 1 | Write enable |
| wrBase | input | 7 | Write base register |
| wrIdx | input | 7 | Write element index |
| wrWid | input | 2 | Write element width code |
| wrData | input | 64 | Write data; only the low element bits are used |

## Verification
Read data is due in the same cycle as the address, with no register on the path. The bench therefore samples both read ports one time unit after it drives inputs at the falling edge, well clear of the rising edge. A write becomes visible only from the cycle after the rising edge that captures it. The reference byte model is updated at that edge, so the check in the write cycle sees old data and the check in the next cycle sees new data. The assertions follow the same one-edge spacing for writes landing and for data holding steady.

// File: rtl/ewrf_pkg.sv
package ewrf_pkg;
  localparam int unsigned NumRegs  = 128;
  localparam int unsigned RegBits  = 64;
  localparam int unsigned IdxBits  = 7;
  localparam int unsigned NumRd    = 2;
  localparam int unsigned LaneCnt  = RegBits / 8;
  localparam int unsigned RegSel   = $clog2(NumRegs);
  localparam int unsigned ByteSel  = $clog2(LaneCnt);
  localparam int unsigned AddrBits = RegSel + ByteSel;

  typedef enum logic [1:0] {
    EW_D64 = 2'b00,
    EW_B8  = 2'b01,
    EW_H16 = 2'b10,
    EW_W32 = 2'b11
  } elemWidth_t;

  typedef struct packed {
    logic [RegSel-1:0]  regNum;
    logic [ByteSel-1:0] lane;
    elemWidth_t         wid;
  } elemLoc_t;

  typedef struct packed {
    elemLoc_t [NumRd-1:0] rdLoc;
    logic                 wrStrobe;
    elemLoc_t             wrLoc;
    logic [LaneCnt-1:0]   wrLaneMask;
  } rfCtrl_t;

  function automatic logic [1:0] widthLog2(elemWidth_t w);
    case (w)
      EW_B8:   return 2'd0;
      EW_H16:  return 2'd1;
      EW_W32:  return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [RegBits-1:0] widthMask(elemWidth_t w);
    case (w)
      EW_B8:   return RegBits'(64'h0000_0000_0000_00FF);
      EW_H16:  return RegBits'(64'h0000_0000_0000_FFFF);
      EW_W32:  return RegBits'(64'h0000_0000_FFFF_FFFF);
      default: return '1;
    endcase
  endfunction

  function automatic logic [LaneCnt-1:0] laneMask(elemWidth_t w, logic [ByteSel-1:0] lane);
    logic [LaneCnt-1:0] base;
    case (w)
      EW_B8:   base = LaneCnt'(8'h01);
      EW_H16:  base = LaneCnt'(8'h03);
      EW_W32:  base = LaneCnt'(8'h0F);
      default: base = '1;
    endcase
    return base << lane;
  endfunction
endpackage

// File: rtl/ewrf_ctrl.sv
module ewrf_ctrl
  import ewrf_pkg::*;
(
  input  logic [NumRd-1:0][RegSel-1:0]  rdBase,
  input  logic [NumRd-1:0][IdxBits-1:0] rdIdx,
  input  elemWidth_t [NumRd-1:0]        rdWid,
  input  logic                          wrEn,
  input  logic [RegSel-1:0]             wrBase,
  input  logic [IdxBits-1:0]            wrIdx,
  input  elemWidth_t                    wrWid,
  output rfCtrl_t                       ctrl
);
  function automatic elemLoc_t locate(logic [RegSel-1:0] base,
                                      logic [IdxBits-1:0] idx,
                                      elemWidth_t w);
    logic [AddrBits-1:0] byteAddr;
    logic [AddrBits-1:0] offs;
    elemLoc_t loc;
    offs     = AddrBits'(idx) << widthLog2(w);
    byteAddr = {base, {ByteSel{1'b0}}} + offs;
    loc.regNum = byteAddr[AddrBits-1:ByteSel];
    loc.lane   = byteAddr[ByteSel-1:0];
    loc.wid    = w;
    return loc;
  endfunction

  elemLoc_t wrLoc;
  assign wrLoc = locate(wrBase, wrIdx, wrWid);

  for (genvar p = 0; p < NumRd; p++) begin : g_rdLoc
    assign ctrl.rdLoc[p] = locate(rdBase[p], rdIdx[p], rdWid[p]);
  end

  assign ctrl.wrStrobe   = wrEn;
  assign ctrl.wrLoc      = wrLoc;
  assign ctrl.wrLaneMask = laneMask(wrLoc.wid, wrLoc.lane);
endmodule

// File: rtl/ewrf_datapath.sv
module ewrf_datapath
  import ewrf_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  rfCtrl_t                        ctrl,
  input  logic [RegBits-1:0]             wrData,
  output logic [NumRd-1:0][RegBits-1:0]  rdData
);
  logic [RegBits-1:0] regs [NumRegs];
  logic [RegBits-1:0] oldWord;
  logic [RegBits-1:0] laneData;
  logic [RegBits-1:0] mergedWord;

  assign oldWord  = regs[ctrl.wrLoc.regNum];
  assign laneData = (wrData & widthMask(ctrl.wrLoc.wid)) << {ctrl.wrLoc.lane, 3'b000};

  for (genvar j = 0; j < LaneCnt; j++) begin : g_merge
    assign mergedWord[j*8 +: 8] = ctrl.wrLaneMask[j] ? laneData[j*8 +: 8] : oldWord[j*8 +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NumRegs; i++) regs[i] <= '0;
    end else if (ctrl.wrStrobe) begin
      regs[ctrl.wrLoc.regNum] <= mergedWord;
    end
  end

  for (genvar p = 0; p < NumRd; p++) begin : g_read
    logic [RegBits-1:0] srcWord;
    assign srcWord   = regs[ctrl.rdLoc[p].regNum];
    assign rdData[p] = (srcWord >> {ctrl.rdLoc[p].lane, 3'b000}) & widthMask(ctrl.rdLoc[p].wid);
  end
endmodule

// File: rtl/elem_regfile.sv
module elem_regfile
  import ewrf_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [RegSel-1:0]  rdBaseA,
  input  logic [IdxBits-1:0] rdIdxA,
  input  logic [1:0]         rdWidA,
  output logic [RegBits-1:0] rdDataA,
  input  logic [RegSel-1:0]  rdBaseB,
  input  logic [IdxBits-1:0] rdIdxB,
  input  logic [1:0]         rdWidB,
  output logic [RegBits-1:0] rdDataB,
  input  logic               wrEn,
  input  logic [RegSel-1:0]  wrBase,
  input  logic [IdxBits-1:0] wrIdx,
  input  logic [1:0]         wrWid,
  input  logic [RegBits-1:0] wrData
);
  rfCtrl_t ctrl;
  logic [NumRd-1:0][RegSel-1:0]  rdBase;
  logic [NumRd-1:0][IdxBits-1:0] rdIdx;
  elemWidth_t [NumRd-1:0]        rdWid;
  logic [NumRd-1:0][RegBits-1:0] rdData;

  assign rdBase = {rdBaseB, rdBaseA};
  assign rdIdx  = {rdIdxB, rdIdxA};
  assign rdWid  = {elemWidth_t'(rdWidB), elemWidth_t'(rdWidA)};

  ewrf_ctrl u_ctrl (
    .rdBase (rdBase),
    .rdIdx  (rdIdx),
    .rdWid  (rdWid),
    .wrEn   (wrEn),
    .wrBase (wrBase),
    .wrIdx  (wrIdx),
    .wrWid  (elemWidth_t'(wrWid)),
    .ctrl   (ctrl)
  );

  ewrf_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .wrData (wrData),
    .rdData (rdData)
  );

  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];
endmodule

// File: rtl/ewrf_checker.sv
module ewrf_checker
  import ewrf_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [RegSel-1:0]  rdBaseA,
  input logic [IdxBits-1:0] rdIdxA,
  input logic [1:0]         rdWidA,
  input logic [RegBits-1:0] rdDataA,
  input logic [RegSel-1:0]  rdBaseB,
  input logic [IdxBits-1:0] rdIdxB,
  input logic [1:0]         rdWidB,
  input logic [RegBits-1:0] rdDataB,
  input logic               wrEn,
  input logic [RegSel-1:0]  wrBase,
  input logic [IdxBits-1:0] wrIdx,
  input logic [1:0]         wrWid,
  input logic [RegBits-1:0] wrData
);
  // R1: a cycle held in reset leaves both ports reading zero
  p_reset_clears_r1: assert property (@(posedge clk)
    !rstN |=> (!rstN || (rdDataA == '0 && rdDataB == '0)));

  // R2: no bits above an 8-bit or 16-bit element
  p_zero_ext_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((rdWidA == 2'b01) |-> (rdDataA[RegBits-1:8] == '0)) and
    ((rdWidA == 2'b10) |-> (rdDataA[RegBits-1:16] == '0)));

  // R7: the element written at the last edge is read back next cycle
  p_write_lands_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrEn) && rdBaseA == $past(wrBase) &&
     rdIdxA == $past(wrIdx) && rdWidA == $past(wrWid))
    |-> (rdDataA == ($past(wrData) & widthMask(elemWidth_t'(rdWidA)))));

  // R9: without a write and with a steady address, read data holds
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(wrEn) && $stable(rdBaseA) && $stable(rdIdxA) && $stable(rdWidA))
    |-> $stable(rdDataA));

  // R8: identical addresses on both ports give identical data
  p_ports_agree_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdBaseA == rdBaseB && rdIdxA == rdIdxB && rdWidA == rdWidB) |-> (rdDataA == rdDataB));
endmodule

bind elem_regfile ewrf_checker u_chk (.*);

// File: tb/test_elem_regfile.sv
module test_elem_regfile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  rdBaseA = '0, rdIdxA = '0, rdBaseB = '0, rdIdxB = '0, wrBase = '0, wrIdx = '0;
  logic [1:0]  rdWidA = '0, rdWidB = '0, wrWid = '0;
  logic [63:0] rdDataA, rdDataB, wrData = '0;
  logic        wrEn = 1'b0;

  int total = 0;
  int failed = 0;
  bit done = 0;
  logic [7:0] mem [1024];

  always #4 clk = ~clk;

  elem_regfile i_elem_regfile (.*);

  function automatic int eBytes(logic [1:0] w);
    case (w)
      2'b01: return 1;
      2'b10: return 2;
      2'b11: return 4;
      default: return 8;
    endcase
  endfunction

  function automatic int bAddr(logic [6:0] b, logic [6:0] i, logic [1:0] w);
    return (int'(b) * 8 + int'(i) * eBytes(w)) % 1024;
  endfunction

  function automatic logic [63:0] mRead(logic [6:0] b, logic [6:0] i, logic [1:0] w);
    logic [63:0] r = '0;
    int a = bAddr(b, i, w);
    for (int k = 0; k < eBytes(w); k++) r[k*8 +: 8] = mem[(a + k) % 1024];
    return r;
  endfunction

  task automatic mWrite(logic [6:0] b, logic [6:0] i, logic [1:0] w, logic [63:0] d);
    int a = bAddr(b, i, w);
    for (int k = 0; k < eBytes(w); k++) mem[(a + k) % 1024] = d[k*8 +: 8];
  endtask

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      failed++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive one cycle at the falling edge, check reads, update model at the rising edge
  task automatic cyc(string tag,
                     logic [6:0] ab, logic [6:0] ai, logic [1:0] aw,
                     logic [6:0] bb, logic [6:0] bi, logic [1:0] bw,
                     logic we, logic [6:0] wb, logic [6:0] wi, logic [1:0] ww, logic [63:0] wd);
    @(negedge clk);
    rdBaseA = ab; rdIdxA = ai; rdWidA = aw;
    rdBaseB = bb; rdIdxB = bi; rdWidB = bw;
    wrEn = we; wrBase = wb; wrIdx = wi; wrWid = ww; wrData = wd;
    #1;
    check({tag, " portA"}, rdDataA, mRead(ab, ai, aw));
    check({tag, " portB"}, rdDataB, mRead(bb, bi, bw));
    @(posedge clk);
    if (we) mWrite(wb, wi, ww, wd);
  endtask

  task automatic rdOnly(string tag, logic [6:0] b, logic [6:0] i, logic [1:0] w, logic [63:0] exp);
    @(negedge clk);
    wrEn = 1'b0;
    rdBaseA = b; rdIdxA = i; rdWidA = w;
    #1;
    check(tag, rdDataA, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20181111));
    for (int a = 0; a < 1024; a++) mem[a] = 8'h00;
    repeat (3) @(posedge clk);
    // writes attempted during reset must not stick (R1)
    @(negedge clk); wrEn = 1'b1; wrBase = 7'd9; wrWid = 2'b00; wrData = '1;
    @(negedge clk); wrEn = 1'b0; rstN = 1'b1;
    rdOnly("R1 reg9 after reset", 7'd9, 7'd0, 2'b00, 64'h0);
    rdOnly("R1 reg127 after reset", 7'd127, 7'd0, 2'b00, 64'h0);

    // R2 / R5 / R6: full word then partial byte write with junk upper bits
    cyc("R5 setup", 0,0,0, 0,0,0, 1'b1, 7'd5, 7'd0, 2'b00, 64'h1122334455667788);
    cyc("R6 byte write", 0,0,0, 0,0,0, 1'b1, 7'd5, 7'd2, 2'b01, 64'hFFFF_FFFF_FFFF_FFAB);
    rdOnly("R5 neighbours kept", 7'd5, 7'd0, 2'b00, 64'h1122334455AB7788);
    rdOnly("R2 16-bit idx1", 7'd5, 7'd1, 2'b10, 64'h0000_0000_0000_55AB);
    rdOnly("R2 32-bit idx1", 7'd5, 7'd1, 2'b11, 64'h0000_0000_1122_3344);
    rdOnly("R2 8-bit idx7", 7'd5, 7'd7, 2'b01, 64'h11);

    // R4: index beyond base register
    cyc("R4 write", 0,0,0, 0,0,0, 1'b1, 7'd3, 7'd9, 2'b01, 64'h5A);
    rdOnly("R4 lands reg4 byte1", 7'd4, 7'd0, 2'b00, 64'h0000_0000_0000_5A00);

    // R3: wrap past register 127
    cyc("R3 write", 0,0,0, 0,0,0, 1'b1, 7'd127, 7'd1, 2'b00, 64'hCAFE_F00D_1234_5678);
    rdOnly("R3 wraps to reg0", 7'd0, 7'd0, 2'b00, 64'hCAFE_F00D_1234_5678);

    // R7: same-cycle read old, next cycle new
    cyc("R7 same cycle old", 7'd20,0,2'b00, 7'd20,0,2'b00, 1'b1, 7'd20, 7'd0, 2'b00, 64'hDEAD_BEEF_0BAD_F00D);
    rdOnly("R7 next cycle new", 7'd20, 7'd0, 2'b00, 64'hDEAD_BEEF_0BAD_F00D);

    // R9: enable low ignores data
    cyc("R9 no write", 0,0,0, 0,0,0, 1'b0, 7'd20, 7'd0, 2'b00, 64'h0);
    rdOnly("R9 unchanged", 7'd20, 7'd0, 2'b00, 64'hDEAD_BEEF_0BAD_F00D);

    // R8: two ports at different places
    cyc("R8 dual read", 7'd5, 7'd0, 2'b00, 7'd20, 7'd1, 2'b11, 1'b0, 0, 0, 0, 64'h0);

    // random mix (R2 R3 R5 R8)
    for (int n = 0; n < 4000; n++) begin
      logic [6:0] wb, wi;
      wb = 7'($urandom_range(0, 127));
      wi = 7'($urandom_range(0, 127));
      cyc("R3 random",
          7'($urandom), 7'($urandom), 2'($urandom),
          (n % 5 == 0) ? wb : 7'($urandom), (n % 5 == 0) ? wi : 7'($urandom), 2'($urandom),
          1'($urandom), wb, wi, 2'($urandom), {$urandom, $urandom});
    end

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule